// File: doc/BRIEF.md
# Gaussian-Shaped Continuous-Phase FSK Baseband Modulator

This block converts a serial bit stream into complex baseband samples of a continuous-phase frequency-shift-keyed signal whose frequency pulses are Gaussian-shaped. With a modulation index of one half the result is minimum-shift keying with Gaussian shaping. Each bit is held for `SPS` sample periods and passed through a Gaussian FIR filter that both smooths and interpolates the frequency trajectory. The filtered value is scaled by a programmable gain into a per-sample phase step. A phase accumulator integrates these steps modulo one full turn, and a sine/cosine table turns the phase into I and Q. The output runs at one sample per clock, and a later stage is expected to interpolate and mix it up to an intermediate frequency.

Bits enter through a valid/ready handshake that offers one slot every `SPS` clocks. If no bit is offered in a slot, the previous bit is repeated, so the phase trajectory never breaks. The filter taps are fixed when the design is elaborated from `SPS`, `SPAN` and the bandwidth-time product, and software supplies only the gain and the starting phase.

Top module: `gfsk_baseband_mod`

## Requirements
- R1: After reset is released, `bitReady` is low for one clock, then high for exactly one clock in every `SPS` clocks. A bit is taken at a rising edge where `bitValid` and `bitReady` are both high.
- R2: When a slot passes without a bit being taken, the filter is fed the last bit taken for that symbol period. After reset the last bit counts as 0.
- R3: The filter has `SPS*SPAN+1` taps. Tap k has weight exp(-(t*pi/a)^2), with t = (k - SPS*SPAN/2)/SPS and a = sqrt(ln2/2)/BT, where BT = `BT_MILLI`/1000. Each weight is normalised by the sum of all weights and rounded to an integer in units of 2^-16. The centre tap is then set so that the taps sum to exactly 65536.
- R4: A bit value of 0 enters the filter as -1 and a value of 1 as +1. The filter runs once per sample on the held bit. A long run of equal bits therefore gives a frequency value of exactly -65536 or +65536.
- R5: The 24-bit phase step is floor(freq * gain / 256), where freq is the filter output and `gain` is an unsigned value in units of 2^-16 equal to index/(2*SPS). For GMSK at SPS=4 the gain is 4096, and a run of ones advances the phase by exactly 2^20 per sample.
- R6: The phase is an unsigned 24-bit fraction of a turn that wraps modulo 2^24. A clock edge with `rst_n` low loads `initPhase`, which is the phase offset divided by 2*pi in the same units.
- R7: Let p be the top 10 bits of the phase. Then `iOut` = round(32767*cos(2*pi*(p+0.5)/1024)) and `qOut` = round(32767*sin(2*pi*(p+0.5)/1024)), both signed 16-bit.
- R8: During reset, `sampleValid`, `iOut` and `qOut` are 0. `sampleValid` rises one clock after `bitReady` first goes high and stays high. The frequency register starts at 0, so the first two valid samples both show `initPhase`. Each later sample shows the phase before the most recent step. That step was computed from the filter output of the previous clock.
- R9: With `gain` at 0, the phase stops advancing and the outputs hold constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one output sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bitData | input | 1 | Data bit offered to the modulator |
| bitValid | input | 1 | High when `bitData` holds a bit |
| bitReady | output | 1 | High in the one clock of each symbol period when a bit is taken |
| gain | input | 16 | Phase-step gain, unsigned, units of 2^-16 |
| initPhase | input | 24 | Starting phase in units of 2^-24 turn, loaded during reset |
| iOut | output | 16 | In-phase sample, signed |
| qOut | output | 16 | Quadrature sample, signed |
| sampleValid | output | 1 | High once the I/Q outputs carry modulated samples |

## Verification
Long runs of ones, then of zeros, show whether the taps sum exactly to unity and whether the bipolar mapping has the right sign, because the phase must then move by exactly +64 or -64 table steps per sample. Withholding `bitValid` after a run of each polarity separates bit repetition from a fall-back to a fixed value. A zero gain separates the gain path from the rest of the phase integration. Random bit streams with idle slots, changing gains and random starting phases across repeated resets exercise the filter transients, the floor rounding of negative steps and the accumulator wrap against a sample-by-sample model.

// File: rtl/gfsk_pkg.sv
package gfsk_pkg;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic tick;   // one sample period elapses at this edge
    logic slot;   // this sample period may take a new bit
  } ctrl_strobe_t;

  localparam real PI_R  = 3.14159265358979323846;
  localparam real LN2_R = 0.69314718055994530942;

  // exp(-y) for y >= 0: halve the argument, use a short series, then square back
  function automatic real expNeg(input real y);
    real x;
    real term;
    real sum;
    int  halvings;
    x = y;
    halvings = 0;
    for (int i = 0; i < 40; i++) begin
      if (x > 0.25) begin
        x = x / 2.0;
        halvings++;
      end
    end
    sum  = 1.0;
    term = 1.0;
    for (int n = 1; n <= 16; n++) begin
      term = -term * x / real'(n);
      sum  = sum + term;
    end
    for (int i = 0; i < 40; i++) begin
      if (i < halvings) sum = sum * sum;
    end
    return sum;
  endfunction

  // sine for an argument in [0, pi/2] by its odd series
  function automatic real sinRad(input real a);
    real term;
    real sum;
    term = a;
    sum  = a;
    for (int n = 1; n <= 14; n++) begin
      term = -term * a * a / real'((2 * n) * (2 * n + 1));
      sum  = sum + term;
    end
    return sum;
  endfunction

endpackage

// File: rtl/gfsk_ctrl.sv
module gfsk_ctrl
  import gfsk_pkg::*;
#(
  parameter int SPS = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  output ctrl_strobe_t strobes,
  output logic         bitReady
);

  localparam int CNT_W = (SPS > 1) ? $clog2(SPS) : 1;
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SPS - 1);

  logic             running;
  logic [CNT_W-1:0] slotCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      slotCnt <= '0;
    end else begin
      running <= 1'b1;
      if (running) begin
        if (slotCnt == LAST_SLOT) slotCnt <= '0;
        else                      slotCnt <= slotCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strobes.tick = running;
    strobes.slot = running && (slotCnt == '0);
  end

  assign bitReady = strobes.slot;

endmodule

// File: rtl/gfsk_sincos.sv
module gfsk_sincos
  import gfsk_pkg::*;
#(
  parameter int LUT_AW = 10,
  parameter int AMP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [LUT_AW-1:0]       phaseIdx,
  output logic signed [AMP_W-1:0] cosOut,
  output logic signed [AMP_W-1:0] sinOut
);

  localparam int  QUARTER    = 2 ** (LUT_AW - 2);
  localparam int  FULL_SCALE = 2 ** (AMP_W - 1) - 1;
  localparam logic [LUT_AW-1:0] QUARTER_OFS = LUT_AW'(QUARTER);

  // First quadrant sampled at bin centres, so both mirrors are exact
  function automatic logic [QUARTER*AMP_W-1:0] buildQuarter();
    logic [QUARTER*AMP_W-1:0] tab;
    real ang;
    int  val;
    tab = '0;
    for (int i = 0; i < QUARTER; i++) begin
      ang = 2.0 * PI_R * (real'(i) + 0.5) / real'(4 * QUARTER);
      val = $rtoi(real'(FULL_SCALE) * sinRad(ang) + 0.5);
      tab[i*AMP_W +: AMP_W] = AMP_W'(val);
    end
    return tab;
  endfunction

  localparam logic [QUARTER*AMP_W-1:0] QTAB = buildQuarter();

  function automatic logic signed [AMP_W-1:0] sineOf(input logic [LUT_AW-1:0] a);
    logic [LUT_AW-3:0]       idx;
    logic signed [AMP_W-1:0] mag;
    idx = a[LUT_AW-2] ? ~a[LUT_AW-3:0] : a[LUT_AW-3:0];
    mag = $signed(QTAB[int'(idx)*AMP_W +: AMP_W]);
    return a[LUT_AW-1] ? -mag : mag;
  endfunction

  logic [LUT_AW-1:0] cosIdx;
  assign cosIdx = phaseIdx + QUARTER_OFS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cosOut <= '0;
      sinOut <= '0;
    end else if (en) begin
      cosOut <= sineOf(cosIdx);
      sinOut <= sineOf(phaseIdx);
    end
  end

endmodule

// File: rtl/gfsk_datapath.sv
module gfsk_datapath
  import gfsk_pkg::*;
#(
  parameter int SPS      = 4,
  parameter int SPAN     = 4,
  parameter int BT_MILLI = 300,
  parameter int GAIN_W   = 16,
  parameter int PHASE_W  = 24,
  parameter int LUT_AW   = 10,
  parameter int AMP_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctrl_strobe_t            strobes,
  input  logic                    bitData,
  input  logic                    bitValid,
  input  logic [GAIN_W-1:0]       gain,
  input  logic [PHASE_W-1:0]      initPhase,
  output logic signed [AMP_W-1:0] iOut,
  output logic signed [AMP_W-1:0] qOut,
  output logic                    sampleValid
);

  localparam int  NTAPS    = SPS * SPAN + 1;
  localparam int  CIDX     = NTAPS / 2;
  localparam int  TAP_FRAC = 16;
  localparam int  UNITY    = 2 ** TAP_FRAC;
  localparam int  TAP_W    = TAP_FRAC + 1;
  localparam int  FREQ_W   = TAP_FRAC + 2;
  localparam int  PROD_W   = FREQ_W + GAIN_W + 1;
  localparam int  SHIFT    = TAP_FRAC + GAIN_W - PHASE_W;
  localparam real BT_R     = real'(BT_MILLI) / 1000.0;

  // Gaussian exponent at tap k: (t*pi/a)^2 = t^2 * pi^2 * 2 * BT^2 / ln2
  function automatic real gaussArg(input int k);
    real t;
    t = (real'(k) - real'(SPS * SPAN) / 2.0) / real'(SPS);
    return t * t * PI_R * PI_R * 2.0 * BT_R * BT_R / LN2_R;
  endfunction

  function automatic logic [NTAPS*TAP_W-1:0] buildTaps();
    logic [NTAPS*TAP_W-1:0] taps;
    real total;
    int  q;
    int  restSum;
    total = 0.0;
    for (int k = 0; k < NTAPS; k++) total = total + expNeg(gaussArg(k));
    taps    = '0;
    restSum = 0;
    for (int k = 0; k < NTAPS; k++) begin
      if (k != CIDX) begin
        q = $rtoi(real'(UNITY) * expNeg(gaussArg(k)) / total + 0.5);
        restSum = restSum + q;
        taps[k*TAP_W +: TAP_W] = TAP_W'(q);
      end
    end
    taps[CIDX*TAP_W +: TAP_W] = TAP_W'(UNITY - restSum);
    return taps;
  endfunction

  localparam logic [NTAPS*TAP_W-1:0] TAPS = buildTaps();

  // Bit history at the sample rate, newest in bit 0
  logic [NTAPS-1:0] bitHist;
  logic             heldBit;
  logic             feedBit;

  assign feedBit = (strobes.slot && bitValid) ? bitData : heldBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bitHist <= '0;
      heldBit <= 1'b0;
    end else if (strobes.tick) begin
      bitHist <= {bitHist[NTAPS-2:0], feedBit};
      heldBit <= feedBit;
    end
  end

  // Bipolar FIR: each tap is added for a one and subtracted for a zero
  logic signed [FREQ_W-1:0] firSum;
  logic signed [FREQ_W-1:0] tapVal;

  always_comb begin
    firSum = '0;
    tapVal = '0;
    for (int k = 0; k < NTAPS; k++) begin
      tapVal = $signed(FREQ_W'(TAPS[k*TAP_W +: TAP_W]));
      firSum = bitHist[k] ? (firSum + tapVal) : (firSum - tapVal);
    end
  end

  logic signed [FREQ_W-1:0] freqReg;

  always_ff @(posedge clk) begin
    if (!rst_n)            freqReg <= '0;
    else if (strobes.tick) freqReg <= firSum;
  end

  // Frequency times gain, scaled to accumulator units with floor rounding
  logic signed [PROD_W-1:0] freqExt;
  logic signed [PROD_W-1:0] gainExt;
  logic signed [PROD_W-1:0] prod;
  logic [PHASE_W-1:0]       phaseStep;

  assign freqExt = {{(PROD_W - FREQ_W){freqReg[FREQ_W-1]}}, freqReg};
  assign gainExt = {{(PROD_W - GAIN_W){1'b0}}, gain};
  assign prod    = freqExt * gainExt;

  generate
    if (SHIFT >= 0) begin : g_shift_down
      assign phaseStep = PHASE_W'(prod >>> SHIFT);
    end else begin : g_shift_up
      assign phaseStep = PHASE_W'(prod <<< (-SHIFT));
    end
  endgenerate

  logic [PHASE_W-1:0] phaseAcc;

  always_ff @(posedge clk) begin
    if (!rst_n)            phaseAcc <= initPhase;
    else if (strobes.tick) phaseAcc <= phaseAcc + phaseStep;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sampleValid <= 1'b0;
    else        sampleValid <= strobes.tick;
  end

  gfsk_sincos #(
    .LUT_AW (LUT_AW),
    .AMP_W  (AMP_W)
  ) lut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (strobes.tick),
    .phaseIdx (phaseAcc[PHASE_W-1 -: LUT_AW]),
    .cosOut   (iOut),
    .sinOut   (qOut)
  );

endmodule

// File: rtl/gfsk_baseband_mod.sv
module gfsk_baseband_mod
  import gfsk_pkg::*;
#(
  parameter int SPS      = 4,
  parameter int SPAN     = 4,
  parameter int BT_MILLI = 300,
  parameter int GAIN_W   = 16,
  parameter int PHASE_W  = 24,
  parameter int LUT_AW   = 10,
  parameter int AMP_W    = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bitData,
  input  logic                    bitValid,
  output logic                    bitReady,
  input  logic [GAIN_W-1:0]       gain,
  input  logic [PHASE_W-1:0]      initPhase,
  output logic signed [AMP_W-1:0] iOut,
  output logic signed [AMP_W-1:0] qOut,
  output logic                    sampleValid
);

  ctrl_strobe_t strobes;

  gfsk_ctrl #(
    .SPS (SPS)
  ) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .bitReady (bitReady)
  );

  gfsk_datapath #(
    .SPS      (SPS),
    .SPAN     (SPAN),
    .BT_MILLI (BT_MILLI),
    .GAIN_W   (GAIN_W),
    .PHASE_W  (PHASE_W),
    .LUT_AW   (LUT_AW),
    .AMP_W    (AMP_W)
  ) dp_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobes     (strobes),
    .bitData     (bitData),
    .bitValid    (bitValid),
    .gain        (gain),
    .initPhase   (initPhase),
    .iOut        (iOut),
    .qOut        (qOut),
    .sampleValid (sampleValid)
  );

endmodule

// File: rtl/gfsk_baseband_mod_chk.sv
module gfsk_baseband_mod_chk #(
  parameter int SPS    = 4,
  parameter int GAIN_W = 16,
  parameter int AMP_W  = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    bitReady,
  input logic                    sampleValid,
  input logic [GAIN_W-1:0]       gain,
  input logic signed [AMP_W-1:0] iOut,
  input logic signed [AMP_W-1:0] qOut
);

  localparam longint FULL    = longint'(2 ** (AMP_W - 1) - 1);
  localparam longint FULL_SQ = FULL * FULL;
  localparam longint MAG_TOL = FULL_SQ / 4096;

  int     gapCnt;
  logic   seenReady;
  int     upCnt;
  longint magSq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gapCnt    <= 0;
      seenReady <= 1'b0;
      upCnt     <= 0;
    end else begin
      if (bitReady) begin
        gapCnt    <= 0;
        seenReady <= 1'b1;
      end else begin
        gapCnt <= gapCnt + 1;
      end
      if (upCnt < 7) upCnt <= upCnt + 1;
    end
  end

  always_comb magSq = longint'(iOut) * longint'(iOut) + longint'(qOut) * longint'(qOut);

  // R1: slots recur with exactly SPS clocks between them
  p_slot_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bitReady && seenReady) |-> (gapCnt == SPS - 1));

  // R1: never more than SPS clocks without a slot once slots have started
  p_slot_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    seenReady |-> (gapCnt < SPS));

  // R8: once valid, samples stay valid
  p_valid_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |=> sampleValid);

  // R8: valid rises right after the first slot
  p_valid_after_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt >= 2 && $rose(sampleValid)) |-> $past(bitReady));

  // R7: every valid sample lies on the unit circle within rounding
  p_unit_circle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sampleValid |-> ((magSq > FULL_SQ - MAG_TOL) && (magSq < FULL_SQ + MAG_TOL)));

  // R9: a gain held at zero freezes the outputs
  p_gain_zero_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upCnt >= 4 && gain == '0 && $past(gain) == '0 && $past(gain, 2) == '0
     && sampleValid && $past(sampleValid)) |-> ($stable(iOut) && $stable(qOut)));

endmodule

bind gfsk_baseband_mod gfsk_baseband_mod_chk #(
  .SPS    (SPS),
  .GAIN_W (GAIN_W),
  .AMP_W  (AMP_W)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bitReady    (bitReady),
  .sampleValid (sampleValid),
  .gain        (gain),
  .iOut        (iOut),
  .qOut        (qOut)
);

// File: tb/gfsk_baseband_mod_tb_top.sv
module gfsk_baseband_mod_tb_top;

  localparam int SPS      = 4;
  localparam int SPAN     = 4;
  localparam int BT_MILLI = 300;
  localparam int NT       = SPS * SPAN + 1;
  localparam int FS       = 32767;
  localparam real PI_V    = 3.14159265358979323846;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               bitData = 1'b0;
  logic               bitValid = 1'b0;
  logic [15:0]        gain = 16'd4096;
  logic [23:0]        initPhase = 24'h400000;
  wire                bitReady;
  wire                sampleValid;
  wire signed [15:0]  iOut;
  wire signed [15:0]  qOut;

  always #4 clk = ~clk;

  gfsk_baseband_mod #(
    .SPS(SPS), .SPAN(SPAN), .BT_MILLI(BT_MILLI),
    .GAIN_W(16), .PHASE_W(24), .LUT_AW(10), .AMP_W(16)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .bitData(bitData), .bitValid(bitValid),
    .bitReady(bitReady), .gain(gain), .initPhase(initPhase),
    .iOut(iOut), .qOut(qOut), .sampleValid(sampleValid)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmpOn = 0;
  int tapQ[NT];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
  endfunction

  function automatic int cosAt(input int p);
    return rnd(real'(FS) * $cos(2.0 * PI_V * (real'(p) + 0.5) / 1024.0));
  endfunction

  function automatic int sinAt(input int p);
    return rnd(real'(FS) * $sin(2.0 * PI_V * (real'(p) + 0.5) / 1024.0));
  endfunction

  function automatic int absi(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // table index whose I/Q pair matches the observed outputs
  function automatic int findIdx(input int iv, input int qv);
    for (int p = 0; p < 1024; p++)
      if (absi(cosAt(p) - iv) <= 1 && absi(sinAt(p) - qv) <= 1) return p;
    return -1;
  endfunction

  // Taps from the Gaussian profile (R3)
  initial begin
    real bt, alpha, total, t;
    int  rest;
    bt    = real'(BT_MILLI) / 1000.0;
    alpha = $sqrt($ln(2.0) / 2.0) / bt;
    total = 0.0;
    for (int k = 0; k < NT; k++) begin
      t = (real'(k) - real'(SPS * SPAN) / 2.0) / real'(SPS);
      total = total + $exp(-((t * PI_V / alpha) ** 2));
    end
    rest = 0;
    for (int k = 0; k < NT; k++) begin
      t = (real'(k) - real'(SPS * SPAN) / 2.0) / real'(SPS);
      tapQ[k] = $rtoi(65536.0 * $exp(-((t * PI_V / alpha) ** 2)) / total + 0.5);
      if (k != NT / 2) rest += tapQ[k];
    end
    tapQ[NT / 2] = 65536 - rest;
  end

  // Sample-by-sample expectation built from the requirements
  bit     mRun = 0;
  int     mCnt = 0;
  bit     mCur = 0;
  bit     mHist[NT];
  longint mFreq = 0;
  longint mAcc = 0;
  int     mI = 0;
  int     mQ = 0;
  bit     mValid = 0;

  always @(posedge clk) begin
    bit     feed;
    longint f;
    longint stepv;
    if (!rst_n) begin
      mRun = 0; mCnt = 0; mCur = 0; mFreq = 0; mValid = 0; mI = 0; mQ = 0;
      mAcc = longint'(initPhase);
      for (int k = 0; k < NT; k++) mHist[k] = 0;
    end else begin
      if (mRun) begin
        feed   = (mCnt == 0 && bitValid) ? bitData : mCur;
        mI     = cosAt(int'(mAcc >> 14));
        mQ     = sinAt(int'(mAcc >> 14));
        mValid = 1;
        stepv  = (mFreq * longint'(gain)) >>> 8;
        mAcc   = (mAcc + stepv) & 64'hFFFFFF;
        f = 0;
        for (int k = 0; k < NT; k++) f += mHist[k] ? tapQ[k] : -tapQ[k];
        mFreq = f;
        for (int k = NT - 1; k > 0; k--) mHist[k] = mHist[k-1];
        mHist[0] = feed;
        mCur = feed;
        mCnt = (mCnt + 1) % SPS;
      end
      mRun = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmpOn) begin
      chk(bitReady == (mRun && mCnt == 0), "R1", "slot timing", bitReady, mRun && mCnt == 0);
      chk(sampleValid == mValid, "R8", "sample valid", sampleValid, mValid);
      if (mValid) begin
        chk(absi(int'(iOut) - mI) <= 1, "R3,R4,R5,R6,R7", "I sample", iOut, mI);
        chk(absi(int'(qOut) - mQ) <= 1, "R3,R4,R5,R6,R7", "Q sample", qOut, mQ);
      end
    end
  end

  task automatic drive(input int n, input bit v, input bit d);
    repeat (n) begin
      @(negedge clk);
      bitValid = v;
      bitData  = d;
    end
  endtask

  task automatic stepCheck(input int delta, input string req);
    int p0, p1;
    @(negedge clk);
    p0 = findIdx(iOut, qOut);
    @(negedge clk);
    p1 = findIdx(iOut, qOut);
    chk(p0 >= 0 && p1 == ((p0 + delta + 1024) % 1024), req, "phase index step", p1,
        (p0 + delta + 1024) % 1024);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // reset state (R8)
    repeat (4) @(negedge clk);
    chk(bitReady == 0, "R8", "reset bitReady", bitReady, 0);
    chk(sampleValid == 0, "R8", "reset sampleValid", sampleValid, 0);
    chk(iOut == 0 && qOut == 0, "R8", "reset I/Q zero", iOut, 0);
    bitValid = 1; bitData = 1;
    rst_n = 1; cmpOn = 1;
    @(negedge clk);
    chk(sampleValid == 0 && bitReady == 1, "R1", "first slot after release", bitReady, 1);
    @(negedge clk);
    chk(sampleValid == 1, "R8", "valid after first slot", sampleValid, 1);
    chk(iOut == cosAt(256) && qOut == sinAt(256), "R6", "initial phase sample", iOut, cosAt(256));

    // long runs of each polarity (R3, R4, R5)
    drive(60, 1, 1);
    stepCheck(64, "R4");
    drive(60, 1, 0);
    stepCheck(-64, "R4");
    // idle slots repeat the last bit (R2)
    drive(60, 0, 1);
    stepCheck(-64, "R2");
    drive(4, 1, 1);
    drive(60, 0, 0);
    stepCheck(64, "R2");

    // zero gain freezes the output (R9)
    begin
      int i0, q0;
      @(negedge clk);
      gain = 16'd0;
      drive(4, 1, 0);
      i0 = iOut; q0 = qOut;
      for (int n = 0; n < 10; n++) begin
        @(negedge clk);
        bitValid = $urandom % 2; bitData = $urandom % 2;
        chk(iOut == i0 && qOut == q0, "R9", "output frozen at zero gain", iOut, i0);
      end
    end

    // slot count over a window (R1)
    begin
      int seen = 0;
      gain = 16'd4096;
      for (int n = 0; n < 40; n++) begin
        @(negedge clk);
        if (bitReady) seen++;
      end
      chk(seen == 40 / SPS, "R1", "slots in 40 clocks", seen, 40 / SPS);
    end

    // random traffic with changing gain (R5, R6 wrap)
    for (int n = 0; n < 1200; n++) begin
      @(negedge clk);
      bitValid = ($urandom % 4) != 0;
      bitData  = $urandom % 2;
      if (n % 50 == 0) gain = 16'(1024 + $urandom % 64000);
    end

    // second reset with random starting phase (R6)
    for (int r = 0; r < 3; r++) begin
      int p;
      @(negedge clk);
      rst_n = 0; cmpOn = 0;
      initPhase = 24'($urandom);
      p = int'(initPhase >> 14);
      repeat (3) @(negedge clk);
      rst_n = 1; cmpOn = 1;
      @(negedge clk);
      @(negedge clk);
      chk(iOut == cosAt(p) && qOut == sinAt(p), "R6", "reloaded start phase", iOut, cosAt(p));
      for (int n = 0; n < 300; n++) begin
        @(negedge clk);
        bitValid = ($urandom % 3) != 0;
        bitData  = $urandom % 2;
        if (n % 64 == 0) gain = 16'($urandom);
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule